// File: doc/BRIEF.md
# Audio Transceiver Status and Interrupt Unit

This block keeps the error and handshake state of a serial digital audio transceiver and turns it into one level interrupt. It holds a two-stage transmit sample queue that software fills and the serializer drains, and a two-stage receive sample queue that the deserializer fills and software drains. It watches both queues for their failure cases, tracks the two user-information register handshakes, and checks when software rewrites the channel-status word relative to the position inside the 192-frame block.

Software reaches the unit through a small register bus with one-cycle writes and combinational reads. The map is: 0 status, 1 control, 2 transmit sample (write), 3 receive sample (read), 4 transmit user word (write), 5 receive user word (read), 6 channel-status word (write). Reads of 3 and 5 and writes of 2, 4 and 6 have side effects on the queues and the flags. The framing engine supplies per-frame, per-sample and user-word strobes.

Top module: `audio_stat_irq`

## Requirements
- R1: After reset, status reads 0, `irq` is low, `tx_sample` is 0 and the frame position is 0.
- R2: Writes to address 2 fill the first free transmit stage. On each `tx_req` the oldest stage appears on `tx_sample` from the next cycle, in write order. A write while both stages are full replaces the second stage.
- R3: A `tx_req` when both transmit stages are empty keeps `tx_sample` at its previous value and sets status bit 6 (underrun).
- R4: `rx_valid` fills the receive stages. A read of address 3 returns the oldest stage and removes it. When both stages are full and no read happens in that cycle, `rx_valid` replaces the second stage, keeps the oldest one and sets status bit 7 (overrun).
- R5: A write to address 6 always updates `chan_status`. It sets status bit 8 (channel-status error) only while the frame position is below 32.
- R6: The frame position advances by one on `frame_strobe` and wraps from 191 to 0.
- R7: Status bits 8, 7 and 6 are sticky. A write to address 0 clears each bit written as 0 and leaves each bit written as 1. Status bits 5 and 4 and all other status bits ignore status writes.
- R8: When a set event and a write-0 clear hit a sticky bit in the same cycle, the bit ends set.
- R9: Status bit 5 (receive user full) sets on `rx_user_load`, which captures `rx_user_in` for address 5. It clears on a read of address 5. A load in the same cycle as that read leaves it set.
- R10: Status bit 4 (transmit user empty) sets on `tx_user_take` and clears on a write to address 4, which drives `tx_user_data`. The write wins over a same-cycle take.
- R11: Control bit 0 enables transmit errors and bit 1 enables receive errors. Bits 2, 3 and 4 enable the channel-status, overrun and underrun flags. The channel-status and underrun flags raise `irq` only with bit 0 and their own bit set. The overrun flag raises `irq` only with bit 1 and bit 3 set.
- R12: Control bit 5 lets status bit 5 raise `irq`, and control bit 6 does the same for status bit 4. `irq` is the level OR of all enabled active flags. It is valid in the cycle after the flag changes and falls once the last contributor clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tx_req | input | 1 | Serializer asks for the next transmit sample |
| tx_sample | output | 24 | Sample currently handed to the serializer |
| rx_valid | input | 1 | Deserializer delivers a sample |
| rx_data | input | 24 | Received sample |
| frame_strobe | input | 1 | One pulse per audio frame |
| rx_user_load | input | 1 | New receive user word available |
| rx_user_in | input | 32 | Receive user word |
| tx_user_take | input | 1 | Serializer consumed the transmit user word |
| tx_user_data | output | 32 | Transmit user word last written by software |
| chan_status | output | 32 | Channel-status word last written by software |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the queue edges. A third transmit write must overwrite the second stage and not the first, or the sample order breaks. A drained queue must repeat its last sample, and a design that shifts in stale data would emit a wrong sample there. It also hits the same-cycle collisions, where a design that let the clear win would drop an underrun flag or a freshly loaded user word. The channel-status window is tested at frame 31, frame 32 and after the wrap at 191. An off-by-one comparison or a counter that does not wrap shows up as a missing or spurious error flag there. The interrupt gating is driven with each direction enable missing, so an interrupt routed through the wrong direction enable shows up as a spurious level.

// File: rtl/audio_stat_pkg.sv
`timescale 1ns/1ps
// Shared constants for the audio status unit.
// Assumes the status and control layouts below are fixed by software.
package audio_stat_pkg;
    // status bit positions (software decodes these)
    localparam int STAT_CSE = 8;
    localparam int STAT_OVR = 7;
    localparam int STAT_UND = 6;
    localparam int STAT_RXU = 5;
    localparam int STAT_TXU = 4;

    // control bit positions
    localparam int CTL_TXERR = 0;
    localparam int CTL_RXERR = 1;
    localparam int CTL_CSE   = 2;
    localparam int CTL_OVR   = 3;
    localparam int CTL_UND   = 4;
    localparam int CTL_RXU   = 5;
    localparam int CTL_TXU   = 6;
    localparam int CTL_W     = 7;

    // sticky flag index inside the flag unit
    localparam int STICKY_N = 3;
    localparam int SIX_CSE  = 0;
    localparam int SIX_OVR  = 1;
    localparam int SIX_UND  = 2;

    typedef enum logic [2:0] {
        REG_STAT = 3'd0,
        REG_CTRL = 3'd1,
        REG_TXD  = 3'd2,
        REG_RXD  = 3'd3,
        REG_TXU  = 3'd4,
        REG_RXU  = 3'd5,
        REG_CSW  = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;

    // status bit position of sticky flag i
    function automatic int sticky_pos(input int i);
        return (i == SIX_CSE) ? STAT_CSE : (i == SIX_OVR) ? STAT_OVR : STAT_UND;
    endfunction
endpackage

// File: rtl/astat_buf2.sv
`timescale 1ns/1ps
// Two-stage sample queue with a defined failure behaviour.
// RESEND=1: drain side sees a held output register; a pull on an empty
//           queue keeps that register and pulses fault_evt (underrun).
// RESEND=0: drain side sees the oldest stage; a push into a full queue
//           with no pull overwrites the second stage and pulses fault_evt.
// Assumes push and pull may coincide; a pull is judged on the old count.
module astat_buf2 #(
    parameter int W      = 24,
    parameter bit RESEND = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pull,
    output logic [W-1:0] out_data,
    output logic         fault_evt
);
    logic [W-1:0] stg0, stg1;
    logic [1:0]   cnt;
    logic         pull_ok;
    logic [1:0]   slot;

    // a pull succeeds only with data held; the push lands after the shift
    always_comb begin
        pull_ok = pull && (cnt != 2'd0);
        slot    = cnt - {1'b0, pull_ok};
    end

    // stage shift on pull, then fill of the first free stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg0 <= '0;
            stg1 <= '0;
            cnt  <= '0;
        end else begin
            if (pull_ok) stg0 <= stg1;
            if (push) begin
                if (slot == 2'd0) stg0 <= push_data;
                else              stg1 <= push_data;
            end
            if (push) cnt <= (slot == 2'd2) ? 2'd2 : slot + 2'd1;
            else      cnt <= slot;
        end
    end

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);

    generate
        if (RESEND) begin : g_resend
            logic [W-1:0] held;
            // held register takes the oldest stage on every good pull
            always_ff @(posedge clk) begin
                if (!rst_n)       held <= '0;
                else if (pull_ok) held <= stg0;
            end
            assign out_data  = held;
            assign fault_evt = pull && (cnt == 2'd0);

            a_r3_resend_last: assert property (@(posedge clk) disable iff (!rst_n)
                (pull && cnt == 2'd0) |=> $stable(out_data));
        end else begin : g_overwrite
            assign out_data  = stg0;
            assign fault_evt = push && (cnt == 2'd2) && !pull;

            a_r4_oldest_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (push && cnt == 2'd2 && !pull) |=> $stable(out_data));
        end
    endgenerate
endmodule

// File: rtl/astat_frame_pos.sv
`timescale 1ns/1ps
// Frame position inside an audio block, with an early-window flag.
// Assumes one frame_strobe pulse per frame; wraps at FRAMES.
module astat_frame_pos #(
    parameter int FRAMES = 192,
    parameter int LIMIT  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    output logic in_window
);
    localparam int POS_W = $clog2(FRAMES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAMES - 1);
    localparam logic [POS_W-1:0] LIM_POS  = POS_W'(LIMIT);

    logic [POS_W-1:0] pos;

    // advance per frame and wrap at the block boundary
    always_ff @(posedge clk) begin
        if (!rst_n)            pos <= '0;
        else if (frame_strobe) pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end

    assign in_window = (pos < LIM_POS);

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && pos == LAST_POS) |=> (pos == '0));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(pos));
endmodule

// File: rtl/astat_flags.sv
`timescale 1ns/1ps
// Status flags and interrupt gating.
// Sticky error flags clear by a write of 0, with set winning a tie.
// The user handshake flags follow their own set/clear strobes.
// Assumes all event inputs are single-cycle pulses from the top.
module astat_flags
    import audio_stat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stat_wr,
    input  logic [STICKY_N-1:0] keep_bits,
    input  logic [STICKY_N-1:0] sticky_set,
    input  logic                rxu_set,
    input  logic                rxu_clr,
    input  logic                txu_set,
    input  logic                txu_clr,
    input  logic [CTL_W-1:0]    ctrl,
    output logic [DATA_W-1:0]   status_word,
    output logic                irq
);
    logic [STICKY_N-1:0] sticky_q;
    logic                rxu_q, txu_q;

    genvar gi;
    generate
        for (gi = 0; gi < STICKY_N; gi++) begin : g_sticky
            // set event beats a software clear in the same cycle
            always_ff @(posedge clk) begin
                if (!rst_n)              sticky_q[gi] <= 1'b0;
                else if (sticky_set[gi]) sticky_q[gi] <= 1'b1;
                else if (stat_wr && !keep_bits[gi]) sticky_q[gi] <= 1'b0;
            end

            a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (sticky_q[gi] && !(stat_wr && !keep_bits[gi])) |=> sticky_q[gi]);
            a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                sticky_set[gi] |=> sticky_q[gi]);
        end
    endgenerate

    // receive user word: a new load wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n)       rxu_q <= 1'b0;
        else if (rxu_set) rxu_q <= 1'b1;
        else if (rxu_clr) rxu_q <= 1'b0;
    end

    // transmit user word: a software write wins over a take
    always_ff @(posedge clk) begin
        if (!rst_n)       txu_q <= 1'b0;
        else if (txu_clr) txu_q <= 1'b0;
        else if (txu_set) txu_q <= 1'b1;
    end

    // status word assembly at the fixed bit positions
    always_comb begin
        status_word = '0;
        for (int i = 0; i < STICKY_N; i++) status_word[sticky_pos(i)] = sticky_q[i];
        status_word[STAT_RXU] = rxu_q;
        status_word[STAT_TXU] = txu_q;
    end

    // direction enable and flag enable both gate each error source
    always_comb begin
        irq = (ctrl[CTL_TXERR] && ((ctrl[CTL_CSE] && sticky_q[SIX_CSE]) ||
                                   (ctrl[CTL_UND] && sticky_q[SIX_UND])))
           || (ctrl[CTL_RXERR] && ctrl[CTL_OVR] && sticky_q[SIX_OVR])
           || (ctrl[CTL_RXU] && rxu_q)
           || (ctrl[CTL_TXU] && txu_q);
    end

    a_r12_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|sticky_q || rxu_q || txu_q));
    a_r11_no_dir_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CTL_TXERR] && !ctrl[CTL_RXERR] && !(ctrl[CTL_RXU] && rxu_q)
         && !(ctrl[CTL_TXU] && txu_q)) |-> !irq);
    a_r9_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rxu_set |=> rxu_q);
    a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        txu_clr |=> !txu_q);
endmodule

// File: rtl/audio_stat_irq.sv
`timescale 1ns/1ps
// Top of the audio status and interrupt unit.
// Decodes the register bus, owns the control, user and channel-status
// registers, and ties the two sample queues, the frame counter and the
// flag unit together. Assumes bus_wr and bus_rd are single-cycle strobes.
module audio_stat_irq
    import audio_stat_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SAMPLE_W = 24,
    parameter int FRAMES   = 192,
    parameter int CS_LIMIT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [2:0]          bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                tx_req,
    output logic [SAMPLE_W-1:0] tx_sample,
    input  logic                rx_valid,
    input  logic [SAMPLE_W-1:0] rx_data,
    input  logic                frame_strobe,
    input  logic                rx_user_load,
    input  logic [DATA_W-1:0]   rx_user_in,
    input  logic                tx_user_take,
    output logic [DATA_W-1:0]   tx_user_data,
    output logic [DATA_W-1:0]   chan_status,
    output logic                irq
);
    localparam int PAD_W = DATA_W - SAMPLE_W;

    reg_sel_e            sel;
    logic                wr_stat, wr_ctrl, wr_txd, wr_txu, wr_csw;
    logic                rd_rxd, rd_rxu;
    logic [CTL_W-1:0]    ctrl_q;
    logic [DATA_W-1:0]   rx_user_q;
    logic [SAMPLE_W-1:0] rx_head;
    logic                und_evt, ovr_evt, in_window;
    logic [STICKY_N-1:0] sticky_set, keep_bits;
    logic [DATA_W-1:0]   status_word;

    // register strobe decode
    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        wr_stat = bus_wr && (sel == REG_STAT);
        wr_ctrl = bus_wr && (sel == REG_CTRL);
        wr_txd  = bus_wr && (sel == REG_TXD);
        wr_txu  = bus_wr && (sel == REG_TXU);
        wr_csw  = bus_wr && (sel == REG_CSW);
        rd_rxd  = bus_rd && (sel == REG_RXD);
        rd_rxu  = bus_rd && (sel == REG_RXU);
    end

    // software-owned registers and the captured receive user word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            chan_status  <= '0;
            tx_user_data <= '0;
            rx_user_q    <= '0;
        end else begin
            if (wr_ctrl)      ctrl_q       <= bus_wdata[CTL_W-1:0];
            if (wr_csw)       chan_status  <= bus_wdata;
            if (wr_txu)       tx_user_data <= bus_wdata;
            if (rx_user_load) rx_user_q    <= rx_user_in;
        end
    end

    astat_buf2 #(.W(SAMPLE_W), .RESEND(1'b1)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_txd),
        .push_data (bus_wdata[SAMPLE_W-1:0]),
        .pull      (tx_req),
        .out_data  (tx_sample),
        .fault_evt (und_evt)
    );

    astat_buf2 #(.W(SAMPLE_W), .RESEND(1'b0)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_data),
        .pull      (rd_rxd),
        .out_data  (rx_head),
        .fault_evt (ovr_evt)
    );

    astat_frame_pos #(.FRAMES(FRAMES), .LIMIT(CS_LIMIT)) u_fpos (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .in_window    (in_window)
    );

    // sticky event and keep-bit vectors in flag-unit order
    always_comb begin
        sticky_set[SIX_CSE] = wr_csw && in_window;
        sticky_set[SIX_OVR] = ovr_evt;
        sticky_set[SIX_UND] = und_evt;
        for (int i = 0; i < STICKY_N; i++) keep_bits[i] = bus_wdata[sticky_pos(i)];
    end

    astat_flags #(.DATA_W(DATA_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_wr     (wr_stat),
        .keep_bits   (keep_bits),
        .sticky_set  (sticky_set),
        .rxu_set     (rx_user_load),
        .rxu_clr     (rd_rxu),
        .txu_set     (tx_user_take),
        .txu_clr     (wr_txu),
        .ctrl        (ctrl_q),
        .status_word (status_word),
        .irq         (irq)
    );

    // read data mux, valid whenever bus_addr is stable
    always_comb begin
        case (sel)
            REG_STAT: bus_rdata = status_word;
            REG_CTRL: bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctrl_q};
            REG_RXD:  bus_rdata = {{PAD_W{1'b0}}, rx_head};
            REG_RXU:  bus_rdata = rx_user_q;
            default:  bus_rdata = '0;
        endcase
    end

    a_r5_csw_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_csw && !in_window && !status_word[STAT_CSE] && !wr_stat) |=> !status_word[STAT_CSE]);
endmodule

// File: tb/audio_stat_irq_test.sv
`timescale 1ns/1ps
module audio_stat_irq_test;
    localparam int DW = 32;
    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 0, bus_rd = 0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          tx_req = 0, rx_valid = 0, frame_strobe = 0;
    logic [SW-1:0] rx_data = '0;
    logic [SW-1:0] tx_sample;
    logic          rx_user_load = 0, tx_user_take = 0;
    logic [DW-1:0] rx_user_in = '0;
    logic [DW-1:0] tx_user_data, chan_status;
    logic          irq;

    always #4 clk = ~clk;

    audio_stat_irq uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_req(tx_req), .tx_sample(tx_sample), .rx_valid(rx_valid),
        .rx_data(rx_data), .frame_strobe(frame_strobe),
        .rx_user_load(rx_user_load), .rx_user_in(rx_user_in),
        .tx_user_take(tx_user_take), .tx_user_data(tx_user_data),
        .chan_status(chan_status), .irq(irq)
    );

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;
    logic [DW-1:0] rd_last;

    // reference state derived from the requirements
    logic [SW-1:0] m_tq0 = '0, m_tq1 = '0, m_last = '0, m_rq0 = '0, m_rq1 = '0;
    int m_tc = 0, m_rc = 0, m_fpos = 0;
    bit m_cse = 0, m_ovr = 0, m_und = 0, m_rxu = 0, m_txu = 0;
    logic [6:0] m_ctrl = '0;
    logic [DW-1:0] m_cs = '0, m_tuser = '0, m_ruser = '0;

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] m_status();
        logic [DW-1:0] s = '0;
        s[8] = m_cse; s[7] = m_ovr; s[6] = m_und; s[5] = m_rxu; s[4] = m_txu;
        return s;
    endfunction

    function automatic logic [DW-1:0] m_irq();  // R11 R12 gating
        bit e;
        e = (m_ctrl[0] && ((m_ctrl[2] && m_cse) || (m_ctrl[4] && m_und)))
         || (m_ctrl[1] && m_ctrl[3] && m_ovr)
         || (m_ctrl[5] && m_rxu) || (m_ctrl[6] && m_txu);
        return {31'b0, e};
    endfunction

    function automatic logic [DW-1:0] m_rdata(logic [2:0] a);
        case (a)
            3'd0: return m_status();
            3'd1: return {25'b0, m_ctrl};
            3'd3: return {8'b0, m_rq0};
            3'd5: return m_ruser;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_for(logic [2:0] a);
        case (a)
            3'd0: return "R7";
            3'd1: return "R11";
            3'd3: return "R4";
            3'd5: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic model_step();
        bit und_s = 0, ovr_s = 0, cse_s = 0, swr;
        // transmit queue (R2 R3)
        if (tx_req) begin
            if (m_tc > 0) begin m_last = m_tq0; m_tq0 = m_tq1; m_tc--; end
            else und_s = 1;
        end
        if (bus_wr && bus_addr == 3'd2) begin
            if (m_tc == 0) m_tq0 = bus_wdata[SW-1:0]; else m_tq1 = bus_wdata[SW-1:0];
            if (m_tc < 2) m_tc++;
        end
        // receive queue (R4)
        if (bus_rd && bus_addr == 3'd3 && m_rc > 0) begin m_rq0 = m_rq1; m_rc--; end
        if (rx_valid) begin
            if (m_rc == 0) m_rq0 = rx_data; else m_rq1 = rx_data;
            if (m_rc < 2) m_rc++; else ovr_s = 1;
        end
        // channel status window (R5 R6)
        if (bus_wr && bus_addr == 3'd6) begin
            m_cs = bus_wdata;
            if (m_fpos < 32) cse_s = 1;
        end
        if (frame_strobe) m_fpos = (m_fpos == 191) ? 0 : m_fpos + 1;
        // sticky flags (R7 R8)
        swr = bus_wr && bus_addr == 3'd0;
        m_cse = cse_s || (m_cse && !(swr && !bus_wdata[8]));
        m_ovr = ovr_s || (m_ovr && !(swr && !bus_wdata[7]));
        m_und = und_s || (m_und && !(swr && !bus_wdata[6]));
        // user handshakes (R9 R10)
        if (rx_user_load) begin m_rxu = 1; m_ruser = rx_user_in; end
        else if (bus_rd && bus_addr == 3'd5) m_rxu = 0;
        if (bus_wr && bus_addr == 3'd4) begin m_txu = 0; m_tuser = bus_wdata; end
        else if (tx_user_take) m_txu = 1;
        if (bus_wr && bus_addr == 3'd1) m_ctrl = bus_wdata[6:0];
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; tx_req = 0; rx_valid = 0; frame_strobe = 0;
        rx_user_load = 0; tx_user_take = 0;
    endtask

    // one cycle: inputs are already driven just after a falling edge
    task automatic cyc();
        #1;
        if (bus_rd) begin
            rd_last = bus_rdata;
            check(tag_for(bus_addr), bus_rdata, m_rdata(bus_addr));
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R2", {8'b0, tx_sample}, {8'b0, m_last});
        check("R12", {31'b0, irq}, m_irq());
        check("R5", chan_status, m_cs);
        check("R10", tx_user_data, m_tuser);
        idle();
    endtask

    task automatic wr(logic [2:0] a, logic [DW-1:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; cyc();
    endtask

    task automatic rd(logic [2:0] a);
        bus_rd = 1; bus_addr = a; cyc();
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) begin frame_strobe = 1; cyc(); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(3'd0); check("R1", rd_last, 32'h0);
        check("R1", {31'b0, irq}, 32'h0);
        check("R1", {8'b0, tx_sample}, 32'h0);

        // R2 order and overwrite of the second stage
        wr(3'd2, 32'h111111); wr(3'd2, 32'h222222); wr(3'd2, 32'h333333);
        tx_req = 1; cyc(); check("R2", {8'b0, tx_sample}, 32'h111111);
        tx_req = 1; cyc(); check("R2", {8'b0, tx_sample}, 32'h333333);
        // R3 underrun repeats the last sample
        tx_req = 1; cyc(); check("R3", {8'b0, tx_sample}, 32'h333333);
        rd(3'd0); check("R3", rd_last, 32'h40);

        // R7 write 1 keeps, write 0 clears
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0); check("R7", rd_last, 32'h40);
        wr(3'd0, 32'hFFFF_FFBF); rd(3'd0); check("R7", rd_last, 32'h0);

        // R8 set and clear in the same cycle
        tx_req = 1; wr(3'd0, 32'h0);
        rd(3'd0); check("R8", rd_last, 32'h40);
        wr(3'd0, 32'h0);

        // R4 overrun keeps oldest, replaces second
        rx_valid = 1; rx_data = 24'hD0D0D0; cyc();
        rx_valid = 1; rx_data = 24'hE0E0E0; cyc();
        rx_valid = 1; rx_data = 24'hF0F0F0; cyc();
        rd(3'd0); check("R4", rd_last, 32'h80);
        rd(3'd3); check("R4", rd_last, 32'hD0D0D0);
        rd(3'd3); check("R4", rd_last, 32'hF0F0F0);
        wr(3'd0, 32'h0);

        // R5 R6 channel-status window boundaries
        wr(3'd6, 32'hCAFE_0001); check("R5", chan_status, 32'hCAFE_0001);
        rd(3'd0); check("R5", rd_last, 32'h100); wr(3'd0, 32'h0);
        strobes(31);
        wr(3'd6, 32'h31); rd(3'd0); check("R5", rd_last, 32'h100); wr(3'd0, 32'h0);
        strobes(1);
        wr(3'd6, 32'h32); rd(3'd0); check("R5", rd_last, 32'h0);
        strobes(160);
        wr(3'd6, 32'h0); rd(3'd0); check("R6", rd_last, 32'h100); wr(3'd0, 32'h0);

        // R9 receive user word handshake
        rx_user_load = 1; rx_user_in = 32'hA5A5_0001; cyc();
        rd(3'd0); check("R9", rd_last, 32'h20);
        check("R12", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h20); check("R12", {31'b0, irq}, 32'h1);
        rd(3'd5); check("R9", rd_last, 32'hA5A5_0001);
        check("R9", {31'b0, irq}, 32'h0);
        rx_user_load = 1; rx_user_in = 32'hA5A5_0002; rd(3'd5);
        rd(3'd0); check("R9", rd_last, 32'h20);
        rd(3'd5); check("R9", rd_last, 32'hA5A5_0002);
        wr(3'd1, 32'h0);

        // R10 transmit user word handshake
        tx_user_take = 1; cyc();
        rd(3'd0); check("R10", rd_last, 32'h10);
        wr(3'd1, 32'h40); check("R12", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h5EED_0001); check("R10", tx_user_data, 32'h5EED_0001);
        check("R10", {31'b0, irq}, 32'h0);
        tx_user_take = 1; wr(3'd4, 32'h5EED_0002);
        rd(3'd0); check("R10", rd_last, 32'h0);
        wr(3'd1, 32'h0);

        // R11 direction and flag enables
        tx_req = 1; cyc();
        wr(3'd1, 32'h10); check("R11", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h11); check("R11", {31'b0, irq}, 32'h1);
        wr(3'd1, 32'h12); check("R11", {31'b0, irq}, 32'h0);
        rx_valid = 1; cyc(); rx_valid = 1; cyc(); rx_valid = 1; cyc();
        wr(3'd1, 32'h0A); check("R11", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h0); check("R12", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h0);

        // random phase against the reference
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 10;
            if (r < 3) begin
                bus_wr = 1;
                case ($urandom % 5)
                    0: bus_addr = 3'd0;
                    1: bus_addr = 3'd1;
                    2: bus_addr = 3'd2;
                    3: bus_addr = 3'd4;
                    default: bus_addr = 3'd6;
                endcase
                bus_wdata = $urandom;
            end else if (r < 6) begin
                bus_rd = 1;
                bus_addr = 3'($urandom % 8);
            end
            tx_req       = ($urandom % 4) == 0;
            rx_valid     = ($urandom % 3) == 0;
            rx_data      = SW'($urandom);
            frame_strobe = ($urandom % 2) == 0;
            rx_user_load = ($urandom % 6) == 0;
            rx_user_in   = $urandom;
            tx_user_take = ($urandom % 6) == 0;
            cyc();
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule